// File: doc/BRIEF.md
# Serial Address-Data Register Port

This block is the receive half of a synchronous serial control port. A host shifts 16-bit words in on one data line. A frame-sync line marks the start of each word. Both lines are sampled on the falling edge of the serial clock. The block pairs each address word with the data word that follows it. A write address followed by its data word updates one of six control registers, or hands the value to a downstream data path through a one-cycle strobe. A read address followed by a dummy word raises a one-cycle read request that carries the register address, for a transmit side outside this block.

The address word carries the direction in its top bit and the register number in its low five bits. Registers 0 to 5 hold control values. Registers 6 and 7 are write-only data inputs. Registers 8 and 9 are read-only data outputs. Register numbers 10 to 31 are unused. Nothing is committed until the second word of a pair has fully arrived.

Top module: `serial_regport`

## Requirements
- R1: On each falling edge of `sclk` the block samples `sdi` and `sfs`. An `sfs` sample of 1 while idle means the next 16 falling edges carry one word, most significant bit first.
- R2: While a word is being shifted in, `sfs` is ignored, except on the edge that samples the least significant bit. A 1 there starts the next word on the following edge, with no idle cycle between the words.
- R3: After reset the first word received is an address word, and from then on words alternate strictly between address word and data word.
- R4: An address word with bit 15 = 0 and bits 4..0 in the range 0..5, followed by a data word, writes the data word into control register n = bits 4..0. The new value appears on `ctrl_flat[16n+15:16n]` on the edge that samples the data word's least significant bit. The registers do not change while only the address word has arrived.
- R5: A write to register 6 or 7 pulses `din_stb` for one clock, with `din_sel` = 0 for register 6 and 1 for register 7 and `din_data` = the data word. The control registers are left unchanged.
- R6: A write to registers 8 to 31 is discarded. No control register changes and neither `din_stb` nor `rd_req` pulses.
- R7: An address word with bit 15 = 1 pulses `rd_req` for one clock, with `rd_addr` = bits 4..0, once the dummy data word that follows it is complete. Bits 14..5 are ignored and no register changes.
- R8: While `rst_n` is low, all control registers read zero and `din_stb` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data from the host, MSB first |
| sfs | input | 1 | Frame sync, high one clock before a word's MSB |
| ctrl_flat | output | 96 | Control registers 0..5, register n at bits 16n+15..16n |
| din_stb | output | 1 | One-cycle strobe for a write to register 6 or 7 |
| din_sel | output | 1 | 0 = register 6, 1 = register 7 |
| din_data | output | 16 | Value written to the data input register |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 5 | Register number being read |

## Verification
The assertions assume that the host respects the framing. A word is never shorter than 16 clocks, so a strobe or read pulse cannot be followed by another on the next edge. An `sfs` pulse is also taken to begin a word only when the port is idle or is on the least significant bit. The bench changes `sdi` and `sfs` only on rising edges. It always sends whole words, and it mixes random idle gaps, chained back-to-back words and stray `sfs` pulses in the middle of a word. Each access draws random values for the address bits that are ignored.

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int N_CTRL  = 6,
  parameter int DIN_LO  = 6,
  localparam int CNT_W  = $clog2(WORD_W),
  localparam int FLAT_W = N_CTRL * WORD_W
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sfs,
  output logic [FLAT_W-1:0] ctrl_flat,
  output logic              din_stb,
  output logic              din_sel,
  output logic [WORD_W-1:0] din_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] shreg;
  logic              phase_data;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] ctrl_q [N_CTRL];

  wire              last      = busy && (cnt == CNT_W'(WORD_W - 1));
  wire [WORD_W-1:0] word      = {shreg, sdi};
  wire              wr_commit = last && phase_data && !rw_q;
  wire              din_hit   = (addr_q == ADDR_W'(DIN_LO)) || (addr_q == ADDR_W'(DIN_LO + 1));

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      phase_data <= 1'b0;
      rw_q       <= 1'b0;
      addr_q     <= '0;
      din_stb    <= 1'b0;
      din_sel    <= 1'b0;
      din_data   <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
    end else begin
      din_stb <= 1'b0;
      rd_req  <= 1'b0;
      if (!busy) begin
        busy <= sfs;
        cnt  <= '0;
      end else begin
        shreg <= word[WORD_W-2:0];
        cnt   <= cnt + 1'b1;
        if (last) begin
          busy       <= sfs;
          cnt        <= '0;
          phase_data <= !phase_data;
          if (!phase_data) begin
            rw_q   <= word[WORD_W-1];
            addr_q <= word[ADDR_W-1:0];
          end else if (rw_q) begin
            rd_req  <= 1'b1;
            rd_addr <= addr_q;
          end else if (din_hit) begin
            din_stb  <= 1'b1;
            din_sel  <= (addr_q != ADDR_W'(DIN_LO));
            din_data <= word;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[i] <= '0;
      else if (wr_commit && addr_q == ADDR_W'(i))
        ctrl_q[i] <= word;
    end
    assign ctrl_flat[i*WORD_W +: WORD_W] = ctrl_q[i];
  end

  AST_PHASE_TOGGLE: assert property (@(negedge sclk) disable iff (!rst_n)
    last |=> (phase_data != $past(phase_data)));  // R3
  AST_CTRL_HOLD: assert property (@(negedge sclk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_flat));  // R4
  AST_STB_SHORT: assert property (@(negedge sclk) disable iff (!rst_n)
    din_stb |=> !din_stb);  // R5
  AST_NO_DUAL_PULSE: assert property (@(negedge sclk) disable iff (!rst_n)
    !(din_stb && rd_req));  // R6
  AST_RD_SHORT: assert property (@(negedge sclk) disable iff (!rst_n)
    rd_req |=> !rd_req);  // R7
  AST_IDLE_UNTIL_SYNC: assert property (@(negedge sclk) disable iff (!rst_n)
    (!busy && !sfs) |=> !busy);  // R1

endmodule

// File: tb/tb_serial_regport.sv
module tb_serial_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        sfs = 1'b0;
  logic [95:0] ctrl_flat;
  logic        din_stb, din_sel, rd_req;
  logic [15:0] din_data;
  logic [4:0]  rd_addr;

  serial_regport dut (
    .sclk(clk), .rst_n(rst_n), .sdi(sdi), .sfs(sfs), .ctrl_flat(ctrl_flat),
    .din_stb(din_stb), .din_sel(din_sel), .din_data(din_data),
    .rd_req(rd_req), .rd_addr(rd_addr)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit pend = 0;
  logic [15:0] model [6];

  function automatic logic [95:0] model_flat();
    logic [95:0] f;
    for (int i = 0; i < 6; i++) f[i*16 +: 16] = model[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w, input bit chain, input int glitch);
    if (!pend) begin
      @(posedge clk); sfs = 1'b1; sdi = 1'($urandom);
    end
    for (int i = 15; i >= 0; i--) begin
      @(posedge clk);
      sdi = w[i];
      sfs = (i == 0) ? chain : (i == glitch);
    end
    @(negedge clk); #1;
    pend = chain;
  endtask

  task automatic access(input logic [15:0] aw, input logic [15:0] d,
                        input bit chain_mid, input bit chain_end, input int glitch);
    logic [4:0] a;
    bit exp_rd, exp_stb;
    string tag;
    a = aw[4:0];
    send_word(aw, chain_mid, glitch);
    chk(ctrl_flat == model_flat() && !din_stb && !rd_req, "R4 no commit after address word",
        {ctrl_flat[93:0], din_stb, rd_req}, {model_flat(), 2'b00});
    send_word(d, chain_end, -1);
    exp_rd = aw[15];
    exp_stb = !aw[15] && (a == 5'd6 || a == 5'd7);
    if (aw[15]) tag = "R7 read request";
    else if (a < 5'd6) begin tag = "R4 control write"; model[a] = d; end
    else if (exp_stb) tag = "R5 data input strobe";
    else tag = "R6 discarded write";
    if (glitch >= 0) tag = {tag, " R2 mid-word sync ignored"};
    if (chain_mid || chain_end) tag = {tag, " R2 chained"};
    chk(rd_req == exp_rd && din_stb == exp_stb, tag, {din_stb, rd_req}, {exp_stb, exp_rd});
    chk(ctrl_flat == model_flat(), {tag, " regs"}, ctrl_flat, model_flat());
    if (exp_rd) chk(rd_addr == a, "R7 read address", rd_addr, a);
    if (exp_stb) chk(din_sel == a[0] && din_data == d, "R5 strobe payload",
                     {din_sel, din_data}, {a[0], d});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    sfs = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(ctrl_flat == '0 && !din_stb && !rd_req, "R8 reset state", ctrl_flat, '0);
    @(posedge clk); sfs = 1'b0; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    chk(ctrl_flat == '0 && !din_stb && !rd_req, "R1 idle without sync", ctrl_flat, '0);

    for (int r = 0; r < 6; r++) access({11'h000, 5'(r)}, 16'hA5C0 + 16'(r), 0, 0, -1);
    access(16'h0006, 16'h1357, 0, 0, -1);
    access(16'h0007, 16'hFEDC, 0, 0, -1);
    access(16'h0008, 16'hFFFF, 0, 0, -1);
    access(16'h0009, 16'h1111, 0, 0, -1);
    access(16'h001F, 16'h2222, 0, 0, -1);
    access(16'h7FE2, 16'h3333, 0, 0, -1);
    access(16'h8001, 16'h1234, 0, 0, -1);
    access(16'hFFE5, 16'h0000, 0, 0, -1);
    access(16'h0003, 16'h8001, 1, 1, -1);
    access(16'h0000, 16'h0F0F, 1, 0, 7);
    access(16'h0004, 16'hBEEF, 0, 0, 1);

    for (int k = 0; k < 300; k++) begin
      logic [15:0] aw;
      int g;
      aw = 16'($urandom);
      if ($urandom_range(0, 2) == 0) aw[4:0] = 5'($urandom_range(0, 9));
      g = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 14)) : -1;
      if (!pend) repeat ($urandom_range(0, 3)) @(posedge clk);
      access(aw, 16'($urandom), 1'($urandom), 1'($urandom), g);
    end
    @(posedge clk); sfs = 1'b0;
    repeat (40) @(posedge clk);
    chk(!din_stb && !rd_req, "R3 trailing frame left open", {din_stb, rd_req}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule